// File: doc/BRIEF.md
# Staircase Soft-Start Reference Sequencer

This block produces the digital reference code for a switching regulator's error amplifier at start-up. A DAC outside the block turns the code into the amplifier's reference voltage. When the enable goes high, the code starts at zero and climbs one step at a time. It advances one step after every 32 switching-clock ticks, so the length of the ramp follows the switching frequency. After 64 steps (2048 ticks) the code stays at full scale and a done flag is raised. While the ramp runs, a soft-start-active flag is high.

An overcurrent monitor can request a hiccup while the output is in regulation. The sequencer then forces the code to zero and holds it there for one full soft-start time, which is also 2048 ticks. After that it ramps again from zero. The block ignores hiccup requests while it is already holding or ramping. Dropping the enable returns the block to its idle state, with code zero, on the next clock edge.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `step_code` is 0 and `ss_active` and `ramp_done` are 0.
- R2: In the cycle after `en` rises from idle, `ss_active` is 1 and `step_code` is 0.
- R3: During a ramp, `step_code` equals the number of `tick` pulses since the ramp began, divided by 32 and rounded down. Clock cycles without a tick do not change the code.
- R4: At the 2048th tick of a ramp, `ss_active` falls, `ramp_done` rises and `step_code` stays at 63 (all ones). Further ticks leave all three unchanged while `en` stays high and no hiccup is requested.
- R5: If `hiccup_req` is high in a cycle where `ramp_done` is 1, then in the next cycle `step_code` is 0 and `ramp_done` and `ss_active` are 0.
- R6: After an accepted hiccup, `step_code` stays 0 and `ss_active` stays 0 for 2047 ticks. The 2048th tick raises `ss_active` with `step_code` 0, and a new 2048-tick ramp follows.
- R7: A `hiccup_req` during a ramp or during the zero-hold has no effect on the outputs or on the timing of the ramp or the hold.
- R8: In the cycle after `en` is low, `step_code` is 0 and `ss_active` and `ramp_done` are 0. While `en` stays low, ticks and hiccup requests change nothing.
- R9: `ss_active` and `ramp_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per switching period |
| en | input | 1 | Converter enable; low forces idle |
| hiccup_req | input | 1 | Overcurrent hiccup request (level, sampled each clock) |
| step_code | output | 6 | Reference step index for the DAC |
| ss_active | output | 1 | High while a ramp is in progress |
| ramp_done | output | 1 | High when the reference is at full scale |

## Verification
The ramp is driven with ticks on every clock and with ticks separated by idle gaps. This separates counting ticks from counting clocks. The code is compared with the expected value just before and just after each 32-tick boundary, and at the final boundary, where the done flag should take over from the active flag. Hiccup requests are applied in regulation, in the zero-hold and in the middle of a ramp. This shows that only a request made in regulation is accepted, and that the hold length is not restarted. Dropping the enable in the middle of a ramp, ticking and requesting while disabled, and resetting in the middle of a ramp show that the idle state takes priority.

// File: rtl/ss_seq_pkg.sv
// Package: shared phase encoding for the soft-start sequencer.
// Assumes: nothing beyond the enumeration below.
package ss_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RAMP = 2'd1,
        PH_REG  = 2'd2,
        PH_HOLD = 2'd3
    } ss_phase_e;
endpackage

// File: rtl/ss_tick_counter.sv
// Module: tick counter shared by the ramp and the zero-hold phases.
// Counts tick pulses modulo 2**(STEP_BITS+SUB_BITS). Reports the upper
// STEP_BITS bits as the step index, and flags the tick that wraps the count.
// Assumes: clr takes priority over tick.
module ss_tick_counter #(
    parameter int STEP_BITS = 6,
    parameter int SUB_BITS  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 tick,
    output logic [STEP_BITS-1:0] step_idx,
    output logic                 wrap
);
    localparam int CNT_W = STEP_BITS + SUB_BITS;

    logic [CNT_W-1:0] cnt_q;

    // Count ticks, cleared by reset or by the phase controller.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal tick: the count is all ones and one more tick arrives.
    always_comb begin
        wrap     = tick && (cnt_q == {CNT_W{1'b1}});
        step_idx = cnt_q[CNT_W-1 -: STEP_BITS];
    end
endmodule

// File: rtl/ss_phase_ctrl.sv
// Module: phase controller (idle, ramp, regulation, zero-hold).
// The enable takes priority over every other input. A hiccup request is
// accepted only in regulation. A ramp or a hold ends on the counter wrap.
// Assumes: the wrap input comes from a counter that this block clears.
module ss_phase_ctrl
    import ss_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      hiccup_req,
    input  logic      wrap,
    output ss_phase_e phase,
    output logic      cnt_clr
);
    ss_phase_e phase_q, phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        if (!en) begin
            phase_d = PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: phase_d = PH_RAMP;
                PH_RAMP: if (wrap) phase_d = PH_REG;
                PH_REG:  if (hiccup_req) phase_d = PH_HOLD;
                PH_HOLD: if (wrap) phase_d = PH_RAMP;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Keep the counter at zero outside the phases that time something.
    always_comb begin
        cnt_clr = !en || (phase_q == PH_IDLE) || (phase_q == PH_REG);
        phase   = phase_q;
    end
endmodule

// File: rtl/ss_code_map.sv
// Module: maps the phase and the step index onto the output code and flags.
// Ramp: the index passes through. Regulation: full scale. Otherwise: zero.
// Assumes: purely combinational; its inputs come from registers.
module ss_code_map
    import ss_seq_pkg::*;
#(
    parameter int STEP_BITS = 6
) (
    input  ss_phase_e            phase,
    input  logic [STEP_BITS-1:0] step_idx,
    output logic [STEP_BITS-1:0] step_code,
    output logic                 ss_active,
    output logic                 ramp_done
);
    // Output decode per phase.
    always_comb begin
        step_code = '0;
        ss_active = 1'b0;
        ramp_done = 1'b0;
        case (phase)
            PH_RAMP: begin
                step_code = step_idx;
                ss_active = 1'b1;
            end
            PH_REG: begin
                step_code = {STEP_BITS{1'b1}};
                ramp_done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/softstart_seq.sv
// Module: staircase soft-start reference sequencer (top).
// Ramps a STEP_BITS-wide code from zero to full scale, one step per
// 2**SUB_BITS ticks. Holds full scale in regulation. A hiccup request
// forces a zero-hold of one soft-start time, followed by a new ramp.
// Assumes: tick is a single-cycle pulse synchronous to clk.
module softstart_seq
    import ss_seq_pkg::*;
#(
    parameter int STEP_BITS = 6,
    parameter int SUB_BITS  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 en,
    input  logic                 hiccup_req,
    output logic [STEP_BITS-1:0] step_code,
    output logic                 ss_active,
    output logic                 ramp_done
);
    ss_phase_e            phase;
    logic                 cnt_clr;
    logic                 wrap;
    logic [STEP_BITS-1:0] step_idx;

    ss_tick_counter #(.STEP_BITS(STEP_BITS), .SUB_BITS(SUB_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .tick     (tick),
        .step_idx (step_idx),
        .wrap     (wrap)
    );

    ss_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .hiccup_req (hiccup_req),
        .wrap       (wrap),
        .phase      (phase),
        .cnt_clr    (cnt_clr)
    );

    ss_code_map #(.STEP_BITS(STEP_BITS)) u_map (
        .phase     (phase),
        .step_idx  (step_idx),
        .step_code (step_code),
        .ss_active (ss_active),
        .ramp_done (ramp_done)
    );
endmodule

// File: rtl/softstart_seq_checker.sv
// Module: property checker for softstart_seq, attached by bind.
// Assumes: observes only the top-level ports.
module softstart_seq_checker #(
    parameter int STEP_BITS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 en,
    input logic                 hiccup_req,
    input logic [STEP_BITS-1:0] step_code,
    input logic                 ss_active,
    input logic                 ramp_done
);
    a_r3_no_move_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_active && !tick) |=> (!ss_active || $stable(step_code)));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_active && tick) |=> (!ss_active || step_code == $past(step_code)
            || step_code == STEP_BITS'($past(step_code) + 1'b1)));

    a_r4_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> (step_code == {STEP_BITS{1'b1}}));

    a_r4_stays_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && en && !hiccup_req) |=> ramp_done);

    a_r5_hiccup_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && en && hiccup_req) |=> (step_code == '0 && !ramp_done && !ss_active));

    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (step_code == '0 && !ss_active && !ramp_done));

    a_r9_exclusive_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(ss_active && ramp_done));
endmodule

bind softstart_seq softstart_seq_checker #(.STEP_BITS(STEP_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .en         (en),
    .hiccup_req (hiccup_req),
    .step_code  (step_code),
    .ss_active  (ss_active),
    .ramp_done  (ramp_done)
);

// File: tb/softstart_seq_tb.sv
// Bench for softstart_seq: a vector table for the ramp, then directed tests.
module softstart_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic       hiccup_req = 1'b0;
    logic [5:0] step_code;
    logic       ss_active;
    logic       ramp_done;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    softstart_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
        .hiccup_req(hiccup_req), .step_code(step_code),
        .ss_active(ss_active), .ramp_done(ramp_done)
    );

    typedef struct packed {
        int unsigned n;
        int unsigned gap;
        int unsigned code;
        bit          act;
        bit          done;
    } vec_t;

    // Ticks added per row (cumulative from enable), the idle gap after each
    // tick, and the expected outputs afterwards (R3, R4).
    localparam vec_t VEC [8] = '{
        '{n: 31,   gap: 0, code: 0,  act: 1'b1, done: 1'b0},
        '{n: 1,    gap: 2, code: 1,  act: 1'b1, done: 1'b0},
        '{n: 95,   gap: 0, code: 3,  act: 1'b1, done: 1'b0},
        '{n: 1,    gap: 1, code: 4,  act: 1'b1, done: 1'b0},
        '{n: 1000, gap: 0, code: 35, act: 1'b1, done: 1'b0},
        '{n: 919,  gap: 0, code: 63, act: 1'b1, done: 1'b0},
        '{n: 1,    gap: 3, code: 63, act: 1'b0, done: 1'b1},
        '{n: 100,  gap: 1, code: 63, act: 1'b0, done: 1'b1}
    };

    task automatic chk(input string req, input int ec, input bit ea, input bit ed);
        checks++;
        if (step_code != 6'(ec) || ss_active != ea || ramp_done != ed) begin
            failures++;
            $display("FAIL %s: code=%0d act=%0b done=%0b expected code=%0d act=%0b done=%0b",
                     req, step_code, ss_active, ramp_done, ec, ea, ed);
        end
    endtask

    // Apply n single-cycle tick pulses, each followed by gap idle cycles.
    task automatic pulses(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    // One-cycle hiccup request.
    task automatic hiccup();
        hiccup_req = 1'b1;
        @(negedge clk);
        hiccup_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 0, 0, 0);

        // R8: disabled, ticks and hiccups do nothing.
        pulses(40, 0);
        hiccup();
        chk("R8 idle ignores inputs", 0, 0, 0);

        // R2: enable starts a ramp.
        en = 1'b1;
        @(negedge clk);
        chk("R2 ramp start", 0, 1, 0);

        // R3/R4 vector walk.
        for (int v = 0; v < 8; v++) begin
            pulses(int'(VEC[v].n), int'(VEC[v].gap));
            chk($sformatf("R3/R4 vector %0d", v), int'(VEC[v].code), VEC[v].act, VEC[v].done);
        end

        // R5: accepted hiccup in regulation.
        hiccup();
        chk("R5 hiccup to zero", 0, 0, 0);

        // R6 and R7: hold length unaffected by a request inside the hold.
        pulses(1000, 0);
        hiccup();
        chk("R7 hiccup in hold ignored", 0, 0, 0);
        pulses(1047, 0);
        chk("R6 hold before last tick", 0, 0, 0);
        pulses(1, 0);
        chk("R6 re-ramp starts", 0, 1, 0);

        // R7: request mid-ramp ignored.
        pulses(64, 1);
        chk("R3 re-ramp step", 2, 1, 0);
        hiccup();
        chk("R7 hiccup in ramp ignored", 2, 1, 0);
        pulses(32, 0);
        chk("R7 ramp continues", 3, 1, 0);
        pulses(1951, 0);
        chk("R6 re-ramp before end", 63, 1, 0);
        pulses(1, 0);
        chk("R6 re-ramp done", 63, 0, 1);

        // R8: enable dropped mid-ramp.
        hiccup();
        pulses(2048, 0);
        pulses(100, 0);
        chk("R3 ramp after second hiccup", 3, 1, 0);
        en = 1'b0;
        @(negedge clk);
        chk("R8 disable mid-ramp", 0, 0, 0);
        hiccup();
        en = 1'b1;
        @(negedge clk);
        chk("R2 re-enable restarts", 0, 1, 0);

        // R1: reset mid-ramp.
        pulses(100, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-ramp", 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule